// File: doc/BRIEF.md
# DMA Channel Status Tracker

This block keeps the live status of one device-side DMA channel of a USB controller. It follows the channel as it runs. It watches enable writes, which come from software or from a descriptor load. It also watches byte-count decrements from the data mover, packet start and completion events from the endpoint logic, and the channel's FIFO level. From these it keeps an enable flag, an active flag, the remaining byte count and three event flags. The event flags clear when software reads the status word.

All of this is presented as one 32-bit status word. Bits 31:16 hold the remaining count. Bit 6 flags a descriptor load. Bit 5 flags end of buffer. Bit 4 flags end of transfer. Bit 1 is channel active and bit 0 is channel enabled. All other bits read as zero.

The block also raises a request to fetch the next descriptor when the channel is idle and next-descriptor loading is on. The mover, the descriptor fetcher, the FIFO storage and the arbitration between channels sit outside the block. Arbitration reaches it only as a "selected" level. All pins are plain control and status signals, with no back-pressure. Every state change happens on the rising clock edge after its cause, and the status word shows the registered state.

Top module: `dma_chan_status`

## Requirements
- R1: The status word carries the count in bits 31:16, the descriptor-loaded flag in bit 6, the end-of-buffer flag in bit 5, the end-of-transfer flag in bit 4, active in bit 1 and enabled in bit 0. Bits 15:7 and 3:2 read as zero.
- R2: Enabled clears on the edge after a transfer ends. A transfer ends when a decrement runs the count out, or when `pkt_done` and `dev_end` are high together while enabled.
- R3: `next_desc_req` is high whenever enabled is 0 and `load_next` is 1.
- R4: An enable write of 0 while active and `fifo_empty` is low keeps enabled at 1. Enabled then clears on the edge where `fifo_empty` is seen high. If active is 0, the write clears enabled at once.
- R5: Active sets on the edge after `chan_selected` and `pkt_start` are high together while enabled. It clears on the edge after `pkt_done`.
- R6: When a transfer stops with `load_next` at 1, active stays set through the disabled gap and the following descriptor load, until `pkt_done`. When enabled is 0 and `load_next` is 0, active clears on the next edge.
- R7: The end-of-buffer flag sets when a decrement brings a nonzero count to zero. The end-of-transfer flag sets on `pkt_done` with `dev_end` while enabled.
- R8: An enable write with `en_wr_desc` set sets the descriptor-loaded flag. A `status_rd` pulse clears bits 6, 5 and 4 on the next edge.
- R9: If a flag's set event and `status_rd` occur in the same cycle, the flag ends up set.
- R10: An enable write of 1 loads the count from `cnt_init`. A decrement lowers the count by `dec_bytes` and stops at zero. A load in the same cycle as a decrement wins.
- R11: Synchronous active-high `rst` clears the whole status word.
- R12: Decrement strobes have no effect on the count while enabled is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr_valid | input | 1 | Enable write strobe |
| en_wr_value | input | 1 | Enable value written |
| en_wr_desc | input | 1 | Write comes from a descriptor load |
| load_next | input | 1 | Next-descriptor loading is on |
| cnt_init | input | CNT_W (16) | Count loaded on an enable write of 1 |
| dec_valid | input | 1 | Byte-count decrement strobe |
| dec_bytes | input | DEC_W (11) | Bytes moved by this strobe |
| chan_selected | input | 1 | Channel won arbitration |
| pkt_start | input | 1 | Packet transfer starts |
| pkt_done | input | 1 | Packet transfer completes |
| dev_end | input | 1 | Device ended the transfer with this packet |
| fifo_empty | input | 1 | Channel FIFO is empty |
| status_rd | input | 1 | Status word read strobe |
| status_word | output | CNT_W+16 (32) | Status word |
| next_desc_req | output | 1 | Request to fetch the next descriptor |

## Verification
The bench builds the block with the default parameters. With CNT_W of 16, the count fills the whole upper half of the word. With DEC_W of 11, a single strobe can move more bytes than remain, so saturation is reachable. A small count is also run down by a strobe of exactly the same size, so the exact-zero boundary is covered. The vector walk runs three situations: a drain-delayed disable, a buffer-end reload with the active flag held, and a device-ended transfer. It also collides flag sets with status reads.

// File: rtl/dma_chan_status_pkg.sv
package dma_chan_status_pkg;
  localparam int BIT_EN   = 0;
  localparam int BIT_ACT  = 1;
  localparam int BIT_TR   = 4;
  localparam int BIT_BUF  = 5;
  localparam int BIT_DESC = 6;
  localparam int CNT_LSB  = 16;

  // index of each clear-on-read flag inside the flag bank
  localparam int FLG_TR   = 0;
  localparam int FLG_BUF  = 1;
  localparam int FLG_DESC = 2;
  localparam int NUM_FLG  = 3;
endpackage

// File: rtl/dma_cs_count.sv
module dma_cs_count #(
  parameter int CNT_W = 16,
  parameter int DEC_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  input  logic [DEC_W-1:0] dec_amt,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_zero
);
  logic [CNT_W-1:0] dec_ext;
  logic             covers;

  assign dec_ext  = CNT_W'(dec_amt);
  assign covers   = dec_ext >= cnt;
  assign hit_zero = dec_en && !load && (cnt != '0) && covers;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (dec_en)   cnt <= covers ? '0 : cnt - dec_ext;
  end
endmodule

// File: rtl/dma_cs_ctrl.sv
module dma_cs_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_valid,
  input  logic wr_value,
  input  logic xfer_end,
  input  logic fifo_empty,
  input  logic load_next,
  input  logic sel,
  input  logic pkt_start,
  input  logic pkt_done,
  output logic en,
  output logic act
);
  logic off_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      off_pend <= 1'b0;
    end else if (wr_valid && wr_value) begin
      en       <= 1'b1;
      off_pend <= 1'b0;
    end else if (xfer_end) begin
      en       <= 1'b0;
      off_pend <= 1'b0;
    end else if (wr_valid) begin
      if (act && !fifo_empty) begin
        off_pend <= 1'b1;
      end else begin
        en       <= 1'b0;
        off_pend <= 1'b0;
      end
    end else if (off_pend && fifo_empty) begin
      en       <= 1'b0;
      off_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        act <= 1'b0;
    else if (sel && pkt_start && en) act <= 1'b1;
    else if (pkt_done)               act <= 1'b0;
    else if (!en && !load_next)      act <= 1'b0;
  end
endmodule

// File: rtl/dma_cs_flags.sv
module dma_cs_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set,
  input  logic          rd,
  output logic [NF-1:0] q
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (rd)     q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_chan_status_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEC_W = 11,
  localparam int STAT_W = CNT_LSB + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_wr_valid,
  input  logic              en_wr_value,
  input  logic              en_wr_desc,
  input  logic              load_next,
  input  logic [CNT_W-1:0]  cnt_init,
  input  logic              dec_valid,
  input  logic [DEC_W-1:0]  dec_bytes,
  input  logic              chan_selected,
  input  logic              pkt_start,
  input  logic              pkt_done,
  input  logic              dev_end,
  input  logic              fifo_empty,
  input  logic              status_rd,
  output logic [STAT_W-1:0] status_word,
  output logic              next_desc_req
);
  logic               en, act, buf_evt, tr_evt, load;
  logic [CNT_W-1:0]   cnt;
  logic [NUM_FLG-1:0] flg_set, flg_q;

  assign load   = en_wr_valid && en_wr_value;
  assign tr_evt = en && pkt_done && dev_end;

  dma_cs_count #(.CNT_W(CNT_W), .DEC_W(DEC_W)) u_count (
    .clk(clk), .rst(rst), .load(load), .load_val(cnt_init),
    .dec_en(dec_valid && en), .dec_amt(dec_bytes),
    .cnt(cnt), .hit_zero(buf_evt)
  );

  dma_cs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_valid(en_wr_valid), .wr_value(en_wr_value),
    .xfer_end(buf_evt || tr_evt), .fifo_empty(fifo_empty),
    .load_next(load_next), .sel(chan_selected), .pkt_start(pkt_start),
    .pkt_done(pkt_done), .en(en), .act(act)
  );

  always_comb begin
    flg_set           = '0;
    flg_set[FLG_TR]   = tr_evt;
    flg_set[FLG_BUF]  = buf_evt;
    flg_set[FLG_DESC] = en_wr_valid && en_wr_desc;
  end

  dma_cs_flags #(.NF(NUM_FLG)) u_flags (
    .clk(clk), .rst(rst), .set(flg_set), .rd(status_rd), .q(flg_q)
  );

  always_comb begin
    status_word                     = '0;
    status_word[BIT_EN]             = en;
    status_word[BIT_ACT]            = act;
    status_word[BIT_TR]             = flg_q[FLG_TR];
    status_word[BIT_BUF]            = flg_q[FLG_BUF];
    status_word[BIT_DESC]           = flg_q[FLG_DESC];
    status_word[STAT_W-1:CNT_LSB]   = cnt;
  end

  assign next_desc_req = !en && load_next;
endmodule

// File: rtl/dma_chan_status_chk.sv
module dma_chan_status_chk #(
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              en_wr_valid,
  input logic              en_wr_value,
  input logic              en_wr_desc,
  input logic              load_next,
  input logic              dec_valid,
  input logic              chan_selected,
  input logic              pkt_start,
  input logic              pkt_done,
  input logic              dev_end,
  input logic              fifo_empty,
  input logic              status_rd,
  input logic [STAT_W-1:0] status_word,
  input logic              next_desc_req
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> status_word == '0); // R11

  AST_TR_END_DISABLES: assert property (@(posedge clk) disable iff (rst)
    status_word[0] && pkt_done && dev_end && !(en_wr_valid && en_wr_value)
    |=> !status_word[0] && status_word[4]); // R2

  AST_IDLE_REQUESTS: assert property (@(posedge clk) disable iff (rst)
    $fell(status_word[0]) && load_next |-> next_desc_req); // R3

  AST_DRAIN_HOLDS_EN: assert property (@(posedge clk) disable iff (rst)
    status_word[0] && status_word[1] && !fifo_empty && en_wr_valid && !en_wr_value
    && !dec_valid && !pkt_done |=> status_word[0]); // R4

  AST_ACT_DROPS: assert property (@(posedge clk) disable iff (rst)
    pkt_done && !(chan_selected && pkt_start && status_word[0])
    |=> !status_word[1]); // R5

  AST_DESC_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    status_rd && !(en_wr_valid && en_wr_desc) |=> !status_word[6]); // R8

  AST_DESC_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    en_wr_valid && en_wr_desc |=> status_word[6]); // R9

  AST_NO_COUNT_RISE: assert property (@(posedge clk) disable iff (rst)
    !(en_wr_valid && en_wr_value)
    |=> status_word[STAT_W-1:16] <= $past(status_word[STAT_W-1:16])); // R10
endmodule

bind dma_chan_status dma_chan_status_chk #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst(rst), .en_wr_valid(en_wr_valid), .en_wr_value(en_wr_value),
  .en_wr_desc(en_wr_desc), .load_next(load_next), .dec_valid(dec_valid),
  .chan_selected(chan_selected), .pkt_start(pkt_start), .pkt_done(pkt_done),
  .dev_end(dev_end), .fifo_empty(fifo_empty), .status_rd(status_rd),
  .status_word(status_word), .next_desc_req(next_desc_req)
);

// File: tb/dma_chan_status_tb_top.sv
module dma_chan_status_tb_top;
  localparam int CLK_P = 10;
  localparam int WD_CYC = 5000;

  typedef struct packed {
    bit wv; bit wval; bit wdesc; bit ld;
    bit dv; bit [10:0] dec;
    bit ps; bit pd; bit de; bit sel; bit fe; bit rd;
    bit [15:0] cl; bit [15:0] ecnt; bit [6:0] eflg; bit endr;
    bit [3:0] tag;
  } vec_t;

  localparam int NV = 29;
  // fields: wv wval wdesc ld | dv dec | ps pd de sel fe rd | cl | ecnt eflg endr | tag
  localparam vec_t VEC [NV] = '{
    '{1,1,0,0, 0,11'd0,  0,0,0,0,1,0, 16'd100, 16'd100,7'b0000001,0, 4'd1},  // R1 R10 load
    '{0,0,0,0, 1,11'd30, 0,0,0,0,1,0, 16'd0,   16'd70, 7'b0000001,0, 4'd10}, // R10 decrement
    '{0,0,0,0, 0,11'd0,  1,0,0,1,1,0, 16'd0,   16'd70, 7'b0000011,0, 4'd5},  // R5 active sets
    '{0,0,0,0, 0,11'd0,  0,1,0,0,1,0, 16'd0,   16'd70, 7'b0000001,0, 4'd5},  // R5 active clears
    '{1,0,0,0, 0,11'd0,  0,0,0,0,1,0, 16'd0,   16'd70, 7'b0000000,0, 4'd4},  // R4 immediate off
    '{0,0,0,0, 1,11'd10, 0,0,0,0,1,0, 16'd0,   16'd70, 7'b0000000,0, 4'd12}, // R12 ignored dec
    '{0,0,0,1, 0,11'd0,  0,0,0,0,1,0, 16'd0,   16'd70, 7'b0000000,1, 4'd3},  // R3 request
    '{1,1,1,1, 0,11'd0,  0,0,0,0,1,0, 16'd50,  16'd50, 7'b1000001,0, 4'd8},  // R8 desc flag
    '{0,0,0,0, 0,11'd0,  0,0,0,0,1,1, 16'd0,   16'd50, 7'b0000001,0, 4'd8},  // R8 read clears
    '{0,0,0,0, 0,11'd0,  1,0,0,1,1,0, 16'd0,   16'd50, 7'b0000011,0, 4'd5},  // R5
    '{1,0,0,0, 0,11'd0,  0,0,0,0,0,0, 16'd0,   16'd50, 7'b0000011,0, 4'd4},  // R4 drain pending
    '{0,0,0,0, 0,11'd0,  0,0,0,0,0,0, 16'd0,   16'd50, 7'b0000011,0, 4'd4},  // R4 still held
    '{0,0,0,0, 0,11'd0,  0,1,0,0,0,0, 16'd0,   16'd50, 7'b0000001,0, 4'd4},  // R4 held, act off
    '{0,0,0,0, 0,11'd0,  0,0,0,0,1,0, 16'd0,   16'd50, 7'b0000000,0, 4'd4},  // R4 fifo empty
    '{1,1,0,1, 0,11'd0,  0,0,0,0,1,0, 16'd40,  16'd40, 7'b0000001,0, 4'd10}, // R10
    '{0,0,0,1, 0,11'd0,  1,0,0,1,1,0, 16'd0,   16'd40, 7'b0000011,0, 4'd6},  // R6
    '{0,0,0,1, 1,11'd64, 0,0,0,0,1,0, 16'd0,   16'd0,  7'b0100010,1, 4'd7},  // R2 R7 R10 saturate
    '{0,0,0,1, 0,11'd0,  0,0,0,0,1,0, 16'd0,   16'd0,  7'b0100010,1, 4'd6},  // R6 act held
    '{1,1,1,1, 0,11'd0,  0,0,0,0,1,1, 16'd20,  16'd20, 7'b1000011,0, 4'd9},  // R9 set vs read
    '{0,0,0,0, 0,11'd0,  0,1,1,0,1,0, 16'd0,   16'd20, 7'b1010000,0, 4'd2},  // R2 R7 dev end
    '{0,0,0,0, 0,11'd0,  0,0,0,0,1,1, 16'd0,   16'd20, 7'b0000000,0, 4'd8},  // R8
    '{1,1,0,0, 0,11'd0,  0,0,0,0,1,0, 16'd8,   16'd8,  7'b0000001,0, 4'd10}, // R10
    '{0,0,0,0, 0,11'd0,  1,0,0,1,1,0, 16'd0,   16'd8,  7'b0000011,0, 4'd5},  // R5
    '{0,0,0,0, 1,11'd8,  0,0,0,0,1,1, 16'd0,   16'd0,  7'b0100010,0, 4'd9},  // R9 R7 exact zero
    '{0,0,0,0, 0,11'd0,  0,0,0,0,1,0, 16'd0,   16'd0,  7'b0100000,0, 4'd6},  // R6 act drops
    '{0,0,0,0, 1,11'd5,  0,0,0,0,1,0, 16'd0,   16'd0,  7'b0100000,0, 4'd12}, // R12
    '{1,1,0,0, 1,11'd3,  0,0,0,0,1,0, 16'd10,  16'd10, 7'b0100001,0, 4'd10}, // R10 load wins
    '{1,0,0,0, 0,11'd0,  0,0,0,0,0,0, 16'd0,   16'd10, 7'b0100000,0, 4'd4},  // R4 not active
    '{0,0,0,0, 0,11'd0,  0,0,0,0,1,1, 16'd0,   16'd10, 7'b0000000,0, 4'd8}   // R8
  };

  logic clk = 1'b0, rst = 1'b1;
  logic en_wr_valid, en_wr_value, en_wr_desc, load_next, dec_valid;
  logic chan_selected, pkt_start, pkt_done, dev_end, fifo_empty, status_rd;
  logic [15:0] cnt_init;
  logic [10:0] dec_bytes;
  logic [31:0] status_word;
  logic        next_desc_req;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_status dut_i (
    .clk(clk), .rst(rst), .en_wr_valid(en_wr_valid), .en_wr_value(en_wr_value),
    .en_wr_desc(en_wr_desc), .load_next(load_next), .cnt_init(cnt_init),
    .dec_valid(dec_valid), .dec_bytes(dec_bytes), .chan_selected(chan_selected),
    .pkt_start(pkt_start), .pkt_done(pkt_done), .dev_end(dev_end),
    .fifo_empty(fifo_empty), .status_rd(status_rd), .status_word(status_word),
    .next_desc_req(next_desc_req)
  );

  task automatic drive(input vec_t v);
    en_wr_valid = v.wv;  en_wr_value = v.wval; en_wr_desc = v.wdesc;
    load_next = v.ld;    dec_valid = v.dv;     dec_bytes = v.dec;
    pkt_start = v.ps;    pkt_done = v.pd;      dev_end = v.de;
    chan_selected = v.sel; fifo_empty = v.fe;  status_rd = v.rd;
    cnt_init = v.cl;
  endtask

  task automatic check(input string req, input logic [31:0] exp_s, input logic exp_r);
    n_run++;
    if (status_word !== exp_s || next_desc_req !== exp_r) begin
      n_fail++;
      $display("FAIL %s status=%h req=%b expected status=%h req=%b",
               req, status_word, next_desc_req, exp_s, exp_r);
    end
  endtask

  task automatic run_all();
    vec_t idle;
    idle = '0;
    idle.fe = 1'b1;
    drive(idle);
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset state", 32'h0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(posedge clk);
      #1;
      check($sformatf("R%0d row %0d", VEC[i].tag, i),
            {VEC[i].ecnt, 9'b0, VEC[i].eflg}, VEC[i].endr);
    end
    // R11: reset in the middle of a running transfer
    @(negedge clk);
    drive(idle);
    en_wr_valid = 1'b1; en_wr_value = 1'b1; cnt_init = 16'h1234; en_wr_desc = 1'b1;
    @(posedge clk); #1;
    check("R11 pre-reset load", {16'h1234, 9'b0, 7'b1000001}, 1'b0);
    @(negedge clk);
    drive(idle);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R11 mid-run reset", 32'h0, 1'b0);
    // R3: request follows load_next while disabled, no clock needed
    load_next = 1'b1;
    #1;
    check("R3 idle with load_next", 32'h0, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    load_next = 1'b0;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WD_CYC) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired after %0d cycles, expected completion", WD_CYC);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule